// File: doc/BRIEF.md
# Strap-Gated 1MB Prefetchable Base Window

This block holds a 64-bit base address register that a bridge exposes at two consecutive configuration dwords, and decodes memory addresses from both sides of the bridge against it. The window spans 1MB, so only address bits 63:20 take part in the compare. A primary-side access that falls inside the window is claimed and forwarded downstream. A secondary-side access that falls inside it is left alone by the bridge. Software can therefore reserve memory space for devices that it cannot enumerate directly.

A strap input decides whether the feature exists at all. With the strap low, both dwords read as zero, writes to them are dropped, and nothing is decoded. With the strap high, the low dword reports a prefetchable 64-bit memory type. Software writes bits 31:20 of the low dword and the whole high dword, with per-byte enables. Decode also needs a memory-space enable and a non-zero base, so the register's zero reset value keeps the window closed until it is programmed. Each side supplies a 64-bit flag. For a 32-bit access, its upper address bits count as zero.

Top module: `pfwin_bar_top`

## Requirements
- R1: With the strap high, a read of offset 0x10 returns base bits 31:20 in bits 31:20, zeros in bits 19:4 and the value 4'b1100 in bits 3:0. Writes never change bits 19:0.
- R2: With the strap high, a read of offset 0x14 returns base bits 63:32. A read of any other offset returns zero.
- R3: With the strap low, offsets 0x10 and 0x14 read as zero and writes to them leave the base unchanged. The unchanged value is visible after the strap is raised again.
- R4: A configuration write updates byte lane k (cfg_wdata bits 8k+7:8k) of the addressed dword only when cfg_be[k] is 1.
- R5: After reset the base is zero, so offset 0x10 reads 32'h0000000C and offset 0x14 reads zero.
- R6: One cycle after pri_valid, pri_claim is 1 exactly when decode is enabled and the effective address bits 63:20 equal the base.
- R7: One cycle after sec_valid, sec_ignore is 1 exactly when decode is enabled and the effective address bits 63:20 equal the base.
- R8: Decode is enabled only while strap_en and mem_en are both 1. Otherwise neither output asserts.
- R9: When the 64-bit flag of a side is 0, its address bits 63:32 are treated as zero. Such an access can then match only when the high dword of the base is zero.
- R10: A base of zero disables decode, so no address matches while the base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Feature strap, 1 = window present |
| mem_en | input | 1 | Memory-space enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pri_valid | input | 1 | Primary-side memory address valid |
| pri_dac | input | 1 | Primary access uses 64-bit addressing |
| pri_addr | input | 44 | Primary address bits 63:20 |
| sec_valid | input | 1 | Secondary-side memory address valid |
| sec_dac | input | 1 | Secondary access uses 64-bit addressing |
| sec_addr | input | 44 | Secondary address bits 63:20 |
| pri_claim | output | 1 | Claim-and-forward decision, one cycle after pri_valid |
| sec_ignore | output | 1 | Ignore decision, one cycle after sec_valid |

## Verification
The bench aims at the window edges: the last address inside the window, the address just below the base, and the first address past the 1MB boundary. It also flips each compared address bit in turn. A design that compares too few bits, or compares the wrong bits, would claim the flipped addresses. The bench sweeps all sixteen byte-enable patterns on both dwords. A design that ignores the enables, or that lets software write bits 19:0, would return the wrong read data. It also covers writes made while the strap is low, 32-bit accesses against a base with a non-zero high dword, and a zero base. A design that got any of these wrong would keep stale writes, alias 32-bit accesses into high memory, or claim address zero straight after reset.

// File: rtl/pfwin_pkg.sv
package pfwin_pkg;
  localparam int unsigned ADDR_W    = 64;
  localparam logic [7:0]  OFF_LO    = 8'h10;
  localparam logic [7:0]  OFF_HI    = 8'h14;
  // bit 3 prefetchable, bits 2:1 = 2'b10 for 64-bit, bit 0 memory space
  localparam logic [3:0]  TYPE_BITS = 4'b1100;
endpackage

// File: rtl/pfwin_regs.sv
module pfwin_regs
  import pfwin_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 20,
  parameter int unsigned CFG_AW   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strap_en,
  input  logic                         cfg_wr,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [3:0]                   cfg_be,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  output logic [ADDR_W-WIN_LOG2-1:0]   base
);
  localparam int unsigned LO_W = 32 - WIN_LOG2;
  localparam int unsigned HI_W = ADDR_W - 32;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            sel_lo, sel_hi, wr_lo, wr_hi;

  assign sel_lo = (cfg_addr == CFG_AW'(OFF_LO));
  assign sel_hi = (cfg_addr == CFG_AW'(OFF_HI));
  assign wr_lo  = cfg_wr & strap_en & sel_lo;
  assign wr_hi  = cfg_wr & strap_en & sel_hi;

  // per-bit merge under the byte enable owning that bit
  for (genvar i = WIN_LOG2; i < 32; i++) begin : g_lo_bit
    assign lo_d[i-WIN_LOG2] = cfg_be[i/8] ? cfg_wdata[i] : lo_q[i-WIN_LOG2];
  end
  for (genvar j = 0; j < HI_W; j++) begin : g_hi_bit
    assign hi_d[j] = cfg_be[j/8] ? cfg_wdata[j] : hi_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_hi) begin
      hi_q <= hi_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (strap_en) begin
      if (sel_lo) begin
        cfg_rdata = {lo_q, {(WIN_LOG2-4){1'b0}}, TYPE_BITS};
      end else if (sel_hi) begin
        cfg_rdata = hi_q;
      end
    end
  end

  assign base = {hi_q, lo_q};

  assert_strap_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |-> (cfg_rdata == 32'h0));
  assert_strap_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> $stable(base));
  assert_low_bits_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_en && sel_lo) |-> (cfg_rdata[WIN_LOG2-1:0] == WIN_LOG2'(TYPE_BITS)));
  assert_no_be_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 4'h0) |=> $stable(base));
endmodule

// File: rtl/pfwin_cmp.sv
module pfwin_cmp
  import pfwin_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic [ADDR_W-WIN_LOG2-1:0]  base,
  input  logic                        valid,
  input  logic                        dac,
  input  logic [ADDR_W-1:WIN_LOG2]    addr,
  output logic                        hit
);
  localparam int unsigned BW = ADDR_W - WIN_LOG2;

  logic [BW-1:0] eff;
  logic          hit_d, hit_q;

  // 32-bit access: upper dword of the address counts as zero
  assign eff   = dac ? addr : {{(ADDR_W-32){1'b0}}, addr[31:WIN_LOG2]};
  assign hit_d = valid & enable & (eff == base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;

  assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(valid && enable));
  assert_no_hit_zero_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(base) != '0));
endmodule

// File: rtl/pfwin_bar_top.sv
module pfwin_bar_top
  import pfwin_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 20,
  parameter int unsigned CFG_AW   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strap_en,
  input  logic                       mem_en,
  input  logic                       cfg_wr,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [3:0]                 cfg_be,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic                       pri_valid,
  input  logic                       pri_dac,
  input  logic [ADDR_W-1:WIN_LOG2]   pri_addr,
  input  logic                       sec_valid,
  input  logic                       sec_dac,
  input  logic [ADDR_W-1:WIN_LOG2]   sec_addr,
  output logic                       pri_claim,
  output logic                       sec_ignore
);
  localparam int unsigned BW = ADDR_W - WIN_LOG2;

  logic [BW-1:0] base;
  logic          dec_en;

  pfwin_regs #(.WIN_LOG2(WIN_LOG2), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_en  (strap_en),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .base      (base)
  );

  assign dec_en = strap_en & mem_en & (|base);

  pfwin_cmp #(.WIN_LOG2(WIN_LOG2)) u_cmp_pri (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (dec_en),
    .base   (base),
    .valid  (pri_valid),
    .dac    (pri_dac),
    .addr   (pri_addr),
    .hit    (pri_claim)
  );

  pfwin_cmp #(.WIN_LOG2(WIN_LOG2)) u_cmp_sec (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (dec_en),
    .base   (base),
    .valid  (sec_valid),
    .dac    (sec_dac),
    .addr   (sec_addr),
    .hit    (sec_ignore)
  );

  assert_decode_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strap_en && mem_en) |=> (!pri_claim && !sec_ignore));
  assert_sides_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid && sec_valid && pri_dac == sec_dac && pri_addr == sec_addr)
      |=> (pri_claim == sec_ignore));
endmodule

// File: tb/pfwin_bar_top_tb.sv
`timescale 1ns/1ps
module pfwin_bar_top_tb;
  logic        clk, rst_n, strap_en, mem_en, cfg_wr;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        pri_valid, pri_dac, sec_valid, sec_dac, pri_claim, sec_ignore;
  logic [63:20] pri_addr, sec_addr;

  int total = 0, bad = 0;
  bit done = 0;
  logic [11:0] m_lo;
  logic [31:0] m_hi;

  pfwin_bar_top u_dut (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (strap_en) begin
      if (a == 8'h10) begin
        if (be[2]) m_lo[3:0]  = d[23:20];
        if (be[3]) m_lo[11:4] = d[31:24];
      end else if (a == 8'h14) begin
        for (int k = 0; k < 4; k++) if (be[k]) m_hi[8*k +: 8] = d[8*k +: 8];
      end
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  function automatic logic exp_hit(input logic [63:0] ad, input logic dac);
    logic [63:0] eff;
    logic [63:20] b;
    b = {m_hi, m_lo};
    eff = dac ? ad : {32'h0, ad[31:0]};
    return strap_en && mem_en && (b != 0) && (eff[63:20] == b);
  endfunction

  task automatic probe(input string tag, input logic [63:0] ad, input logic dac);
    logic e;
    e = exp_hit(ad, dac);
    @(negedge clk);
    pri_valid = 1; sec_valid = 1; pri_dac = dac; sec_dac = dac;
    pri_addr = ad[63:20]; sec_addr = ad[63:20];
    @(negedge clk);
    pri_valid = 0; sec_valid = 0;
    check({tag, " R6 claim"}, {31'h0, pri_claim}, {31'h0, e});
    check({tag, " R7 ignore"}, {31'h0, sec_ignore}, {31'h0, e});
  endtask

  task automatic probe_exp(input string tag, input logic [63:0] ad, input logic dac, input logic e);
    @(negedge clk);
    pri_valid = 1; sec_valid = 1; pri_dac = dac; sec_dac = dac;
    pri_addr = ad[63:20]; sec_addr = ad[63:20];
    @(negedge clk);
    pri_valid = 0; sec_valid = 0;
    check({tag, " claim"}, {31'h0, pri_claim}, {31'h0, e});
    check({tag, " ignore"}, {31'h0, sec_ignore}, {31'h0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] b64;
    rst_n = 0; strap_en = 1; mem_en = 1; cfg_wr = 0; cfg_addr = 0; cfg_be = 0;
    cfg_wdata = 0; pri_valid = 0; pri_dac = 0; sec_valid = 0; sec_dac = 0;
    pri_addr = 0; sec_addr = 0; m_lo = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R5 reset state, R10 zero base never decodes
    read_chk("R5 lo", 8'h10, 32'h0000000C);
    read_chk("R5 hi", 8'h14, 32'h0);
    probe_exp("R10 addr0 dac", 64'h0, 1'b1, 1'b0);
    probe_exp("R10 addr0 32b", 64'h0, 1'b0, 1'b0);

    // R2 other offsets
    read_chk("R2 off 0x18", 8'h18, 32'h0);
    read_chk("R2 off 0x0c", 8'h0C, 32'h0);

    // R3 strap low: reads zero, writes dropped
    strap_en = 0;
    cfg_write(8'h14, 4'hF, 32'hFFFF_FFFF);
    cfg_write(8'h10, 4'hF, 32'hFFFF_FFFF);
    read_chk("R3 lo off", 8'h10, 32'h0);
    read_chk("R3 hi off", 8'h14, 32'h0);
    probe_exp("R3 R8 strap low", 64'h0, 1'b0, 1'b0);
    strap_en = 1;
    read_chk("R3 lo kept", 8'h10, 32'h0000000C);
    read_chk("R3 hi kept", 8'h14, 32'h0);

    // R4 byte-enable sweep on both dwords, R1 read format
    for (int be = 0; be < 16; be++) begin
      logic [31:0] d;
      d = 32'hA5C3_0F5A ^ (32'h1111_1111 * be);
      cfg_write(8'h14, be[3:0], d);
      read_chk("R4 hi be", 8'h14, m_hi);
      cfg_write(8'h10, be[3:0], ~d);
      read_chk("R1 R4 lo be", 8'h10, {m_lo, 16'h0, 4'hC});
    end

    // program base 0x00000012_34500000
    cfg_write(8'h14, 4'hF, 32'h0000_0012);
    cfg_write(8'h10, 4'hF, 32'h3450_0000);
    read_chk("R1 lo prog", 8'h10, 32'h3450_000C);
    read_chk("R2 hi prog", 8'h14, 32'h0000_0012);
    b64 = 64'h0000_0012_3450_0000;
    probe_exp("R6 R7 base", b64, 1'b1, 1'b1);
    probe_exp("R6 R7 top of window", b64 + 64'hFFFFF, 1'b1, 1'b1);
    probe_exp("R6 R7 below", b64 - 1, 1'b1, 1'b0);
    probe_exp("R6 R7 past 1MB", b64 + 64'h100000, 1'b1, 1'b0);
    for (int i = 20; i < 64; i++) probe("R6 R7 bit flip", b64 ^ (64'h1 << i), 1'b1);
    probe_exp("R9 32b with hi base", b64, 1'b0, 1'b0);

    // R8 gating
    mem_en = 0;
    probe_exp("R8 mem_en low", b64, 1'b1, 1'b0);
    mem_en = 1;
    strap_en = 0;
    probe_exp("R8 strap low", b64, 1'b1, 1'b0);
    strap_en = 1;
    probe_exp("R8 restored", b64, 1'b1, 1'b1);

    // R9: high dword zero, 32-bit accesses
    cfg_write(8'h14, 4'hF, 32'h0);
    cfg_write(8'h10, 4'hC, 32'hABC0_0000);
    probe_exp("R9 32b hit", 64'h0000_0000_ABC1_2345, 1'b0, 1'b1);
    probe_exp("R9 32b upper ignored", 64'h0000_0007_ABCF_FFFF, 1'b0, 1'b1);
    probe_exp("R9 64b upper nonzero", 64'h0000_0007_ABC0_0000, 1'b1, 1'b0);
    probe_exp("R9 64b upper zero", 64'h0000_0000_ABC0_0000, 1'b1, 1'b1);
    for (int i = 20; i < 32; i++) probe("R9 32b flip", 64'hABC0_0000 ^ (64'h1 << i), 1'b0);

    // R10 base cleared again
    cfg_write(8'h10, 4'hF, 32'h0);
    probe_exp("R10 cleared", 64'h0, 1'b1, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule